// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a register-mapped watchdog for a chip that supplies a slow timebase as a one-clock enable pulse (`tick_i`, nominally 32 kHz). Software arms it by writing a timeout length and a control word, then has to keep writing a fixed restart value before the count runs out. When the count runs out, the block either issues a system reset request at once, or first raises an interrupt and only issues the reset if a second full period passes with no restart.

Protection against runaway software comes from keys. A write to the control or length register lands only if a fixed key pattern sits in a reserved field of the same word. The restart and software-reset registers act only on one exact 32-bit value each. A reset event, whether it comes from expiry or from software, pulses an internal request line for one clock. If enabled, it also drives an external reset pin of programmable polarity for a fixed number of clocks.

Top module: `kwd_watchdog`

## Requirements
- R1: After synchronous reset, the control register reads 0x0000_0005 (running, external pin enabled, pin active low), the length register reads 0xFFFF_FFE0, `irq_o` and `sys_rst_req_o` are low and `ext_rst_o` is high.
- R2: A write to offset 0x00 lands only when bits 31:24 are 0x22. The stored fields are run enable bit 0, pin polarity bit 1 (1 = active high), pin enable bit 2, interrupt enable bit 3, auto-start bit 4, two-stage enable bit 6 and counter select bit 8. All other bits read as zero. A write with any other key leaves the register unchanged.
- R3: A write to offset 0x04 lands only when bits 4:0 are 0x08, and the length is then taken from bits 31:5. Readback shows the length in bits 31:5 and zero in bits 4:0. A write with any other key changes nothing.
- R4: After a restart with the block running, a reset event occurs exactly length × UNIT_TICKS ticks later. A length of 0 behaves as 1.
- R5: Writing exactly 0x0000_1971 to offset 0x08 reloads the count from the length, restarts the unit prescaler, returns the block to its first stage and clears `irq_o`. Any other value written there has no effect.
- R6: When two-stage mode or interrupt enable is clear, expiry raises `sys_rst_req_o` for one clock with no interrupt. Every reset event reloads the count and clears `irq_o`.
- R7: With two-stage mode and interrupt enable both set, the first expiry sets `irq_o` and reloads the count. A second expiry with no restart in between is a reset event. A restart after the interrupt averts the reset and starts a new first stage.
- R8: Writing exactly 0x0000_1209 to offset 0x14 makes `sys_rst_req_o` high in the clock that follows the write, whether or not the block is running. Other values do nothing.
- R9: While run enable is clear, the count holds at the length and no expiry occurs. Setting the bit again starts a full period.
- R10: On each reset event `ext_rst_o` takes its active level for exactly PULSE_CLKS clocks, provided the pin enable bit is set. Otherwise it rests at the inactive level, which is the inverse of the polarity bit.
- R11: The count advances only in clocks where `tick_i` is high. Clocks without a tick neither advance nor lose progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock timebase enable |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the clock after a read strobe |
| irq_o | output | 1 | First-stage expiry interrupt |
| sys_rst_req_o | output | 1 | One-clock system reset request |
| ext_rst_o | output | 1 | External reset pin, programmable polarity |

## Verification
The bench sweeps length values from 0 up in both single- and two-stage configurations and measures the clocks to each event against length × UNIT_TICKS. A design with an off-by-one at the unit boundary, or one that treats a zero length as a huge count, misses those figures by a clock or never fires. Near-miss keys and restart values are written with nothing else changed. A decoder that compares too few bits would then alter the registers or restart the count, and the measured expiry would shift. The pin pulse is counted in clocks for both polarities and with the pin disabled, and ticks are withheld to show that progress holds. A prescaler that reset on idle clocks would then fire late.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 32-bit register word and byte offsets of ADDR_W bits.
package kwd_pkg;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int LEN_KEY_W   = 5;
    localparam int LEN_W       = REG_W - LEN_KEY_W;
    localparam int MODE_KEY_LO = 24;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LEN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_KICK  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SWRST = 8'h14;

    localparam logic [REG_W-MODE_KEY_LO-1:0] CTRL_KEY  = 8'h22;
    localparam logic [LEN_KEY_W-1:0]         LEN_KEY   = 5'h08;
    localparam logic [REG_W-1:0]             KICK_KEY  = 32'h0000_1971;
    localparam logic [REG_W-1:0]             SWRST_KEY = 32'h0000_1209;

    typedef struct packed {
        logic cnt_sel;
        logic two_stage;
        logic auto_start;
        logic irq_en;
        logic pin_en;
        logic pin_pol;
        logic run;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{cnt_sel: 1'b0, two_stage: 1'b0, auto_start: 1'b0,
                                     irq_en: 1'b0, pin_en: 1'b1, pin_pol: 1'b0, run: 1'b1};

    // Unpack a bus word into control fields (bit positions are software-visible).
    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.run        = w[0];
        c.pin_pol    = w[1];
        c.pin_en     = w[2];
        c.irq_en     = w[3];
        c.auto_start = w[4];
        c.two_stage  = w[6];
        c.cnt_sel    = w[8];
        return c;
    endfunction

    // Pack control fields back into a bus word; unused bits read zero.
    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w    = '0;
        w[0] = c.run;
        w[1] = c.pin_pol;
        w[2] = c.pin_en;
        w[3] = c.irq_en;
        w[4] = c.auto_start;
        w[6] = c.two_stage;
        w[8] = c.cnt_sel;
        return w;
    endfunction
endpackage

// File: rtl/kwd_regs.sv
// Register port of the keyed watchdog: key checks, storage, readback and
// decode of the restart and software-reset strobes.
// Assumes at most one access per clock; strobes are combinational from the bus.
module kwd_regs
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output ctrl_t             ctrl_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              kick_o,
    output logic              swrst_o
);
    logic wr_en;
    logic rd_en;
    logic ctrl_ok;
    logic len_ok;

    // Decode keyed writes and magic-value strobes.
    always_comb begin
        wr_en   = bus_valid_i && bus_write_i;
        rd_en   = bus_valid_i && !bus_write_i;
        ctrl_ok = wr_en && (bus_addr_i == OFF_CTRL)
                  && (bus_wdata_i[REG_W-1:MODE_KEY_LO] == CTRL_KEY);
        len_ok  = wr_en && (bus_addr_i == OFF_LEN)
                  && (bus_wdata_i[LEN_KEY_W-1:0] == LEN_KEY);
        kick_o  = wr_en && (bus_addr_i == OFF_KICK)  && (bus_wdata_i == KICK_KEY);
        swrst_o = wr_en && (bus_addr_i == OFF_SWRST) && (bus_wdata_i == SWRST_KEY);
    end

    // Hold the control word; only keyed writes update it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= CTRL_RESET;
        end else if (ctrl_ok) begin
            ctrl_o <= ctrl_from_word(bus_wdata_i);
        end
    end

    // Hold the timeout length; only keyed writes update it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_o <= '1;
        end else if (len_ok) begin
            len_o <= bus_wdata_i[REG_W-1:LEN_KEY_W];
        end
    end

    // Registered readback with key fields reading zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
        end else if (rd_en) begin
            case (bus_addr_i)
                OFF_CTRL: bus_rdata_o <= ctrl_to_word(ctrl_o);
                OFF_LEN:  bus_rdata_o <= {len_o, {LEN_KEY_W{1'b0}}};
                default:  bus_rdata_o <= '0;
            endcase
        end
    end
endmodule

// File: rtl/kwd_timer.sv
// Countdown engine: a tick prescaler of UNIT_TICKS feeding a unit counter,
// plus the two-stage interrupt/reset sequencing.
// Assumes tick_i is a one-clock enable; a zero length acts as one unit.
module kwd_timer
    import kwd_pkg::*;
#(
    parameter int UNIT_TICKS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             two_stage_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             kick_i,
    input  logic             swrst_i,
    output logic             irq_o,
    output logic             expire_rst_o
);
    localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

    logic [LEN_W-1:0] cnt_q;
    logic             stage_q;
    logic             unit_done;
    logic             reload;
    logic             boundary;
    logic             last_unit;
    logic             go_irq;
    logic             go_rst;

    assign reload = kick_i || swrst_i || !run_i;

    generate
        if (UNIT_TICKS > 1) begin : g_pre
            logic [PRE_W-1:0] pre_q;
            // Count ticks within one unit; cleared on any reload.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (reload) begin
                    pre_q <= '0;
                end else if (tick_i) begin
                    pre_q <= unit_done ? '0 : pre_q + 1'b1;
                end
            end
            assign unit_done = (pre_q == PRE_W'(UNIT_TICKS - 1));
        end else begin : g_nopre
            assign unit_done = 1'b1;
        end
    endgenerate

    // Classify the current clock: unit boundary, and which expiry it causes.
    always_comb begin
        boundary  = !reload && tick_i && unit_done;
        last_unit = (cnt_q[LEN_W-1:1] == '0);
        go_irq    = boundary && last_unit && two_stage_i && !stage_q;
        go_rst    = boundary && last_unit && !(two_stage_i && !stage_q);
    end

    assign expire_rst_o = go_rst;

    // Unit counter, stage flag and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '1;
            stage_q <= 1'b0;
            irq_o   <= 1'b0;
        end else if (kick_i || swrst_i) begin
            cnt_q   <= len_i;
            stage_q <= 1'b0;
            irq_o   <= 1'b0;
        end else if (!run_i) begin
            cnt_q   <= len_i;
            stage_q <= 1'b0;
        end else if (go_irq) begin
            cnt_q   <= len_i;
            stage_q <= 1'b1;
            irq_o   <= 1'b1;
        end else if (go_rst) begin
            cnt_q   <= len_i;
            stage_q <= 1'b0;
            irq_o   <= 1'b0;
        end else if (boundary) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/kwd_rstgen.sv
// Reset output stage: one-clock system request and a fixed-width external
// pin pulse at programmable polarity.
// Assumes a new event during a pulse restarts the full pulse width.
module kwd_rstgen #(
    parameter int PULSE_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdt_ev_i,
    input  logic sw_ev_i,
    input  logic pin_en_i,
    input  logic pin_pol_i,
    output logic sys_rst_req_o,
    output logic ext_rst_o
);
    localparam int PW = $clog2(PULSE_CLKS + 1);

    logic [PW-1:0] pcnt_q;
    logic          event_now;

    assign event_now = wdt_ev_i || sw_ev_i;

    // Register the system request and time the pin pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst_req_o <= 1'b0;
            pcnt_q        <= '0;
        end else begin
            sys_rst_req_o <= event_now;
            if (event_now) begin
                pcnt_q <= PW'(PULSE_CLKS);
            end else if (pcnt_q != '0) begin
                pcnt_q <= pcnt_q - 1'b1;
            end
        end
    end

    // Drive the pin at its active level only while enabled and pulsing.
    always_comb begin
        ext_rst_o = (pin_en_i && (pcnt_q != '0)) ? pin_pol_i : !pin_pol_i;
    end
endmodule

// File: rtl/kwd_watchdog.sv
// Top of the keyed two-stage watchdog: register port, countdown engine and
// reset output stage.
// Assumes a single clock domain; tick_i is synchronous to clk.
module kwd_watchdog
    import kwd_pkg::*;
#(
    parameter int UNIT_TICKS = 512,
    parameter int PULSE_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              irq_o,
    output logic              sys_rst_req_o,
    output logic              ext_rst_o
);
    ctrl_t            ctrl_q;
    logic [LEN_W-1:0] len_q;
    logic             kick;
    logic             swrst;
    logic             expire_rst;

    kwd_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid_i (bus_valid_i),
        .bus_write_i (bus_write_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .ctrl_o      (ctrl_q),
        .len_o       (len_q),
        .kick_o      (kick),
        .swrst_o     (swrst)
    );

    kwd_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .run_i        (ctrl_q.run),
        .two_stage_i  (ctrl_q.two_stage && ctrl_q.irq_en),
        .len_i        (len_q),
        .kick_i       (kick),
        .swrst_i      (swrst),
        .irq_o        (irq_o),
        .expire_rst_o (expire_rst)
    );

    kwd_rstgen #(.PULSE_CLKS(PULSE_CLKS)) u_rstgen (
        .clk           (clk),
        .rst_n         (rst_n),
        .wdt_ev_i      (expire_rst),
        .sw_ev_i       (swrst),
        .pin_en_i      (ctrl_q.pin_en),
        .pin_pol_i     (ctrl_q.pin_pol),
        .sys_rst_req_o (sys_rst_req_o),
        .ext_rst_o     (ext_rst_o)
    );
endmodule

// File: rtl/kwd_watchdog_chk.sv
// Property checker for kwd_watchdog, attached by bind below.
// Assumes the same clock and synchronous reset as the design.
module kwd_watchdog_chk
    import kwd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid_i,
    input logic              bus_write_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [REG_W-1:0]  bus_wdata_i,
    input logic              irq_o,
    input logic              sys_rst_req_o,
    input logic              ext_rst_o,
    input ctrl_t             ctrl_q,
    input logic [LEN_W-1:0]  len_q
);
    logic wr;
    logic sw_wr;
    assign wr    = bus_valid_i && bus_write_i;
    assign sw_wr = wr && (bus_addr_i == OFF_SWRST) && (bus_wdata_i == SWRST_KEY);

    p_ctrl_nokey_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i == OFF_CTRL && bus_wdata_i[REG_W-1:MODE_KEY_LO] != CTRL_KEY)
        |=> $stable(ctrl_q));

    p_len_nokey_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i == OFF_LEN && bus_wdata_i[LEN_KEY_W-1:0] != LEN_KEY)
        |=> $stable(len_q));

    p_kick_clears_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i == OFF_KICK && bus_wdata_i == KICK_KEY) |=> !irq_o);

    p_irq_needs_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ctrl_q.run && ctrl_q.two_stage && ctrl_q.irq_en));

    p_swrst_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> sys_rst_req_o);

    p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !sw_wr) |=> !sys_rst_req_o);

    p_pin_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.pin_en |-> (ext_rst_o == !ctrl_q.pin_pol));

    p_pin_on_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req_o && ctrl_q.pin_en) |-> (ext_rst_o == ctrl_q.pin_pol));
endmodule

bind kwd_watchdog kwd_watchdog_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid_i   (bus_valid_i),
    .bus_write_i   (bus_write_i),
    .bus_addr_i    (bus_addr_i),
    .bus_wdata_i   (bus_wdata_i),
    .irq_o         (irq_o),
    .sys_rst_req_o (sys_rst_req_o),
    .ext_rst_o     (ext_rst_o),
    .ctrl_q        (ctrl_q),
    .len_q         (len_q)
);

// File: tb/sim_kwd_watchdog.sv
`timescale 1ns/1ps
module sim_kwd_watchdog;
    localparam int U = 4;
    localparam int P = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        bv = 1'b0;
    logic        bw = 1'b0;
    logic [7:0]  ba = '0;
    logic [31:0] bwd = '0;
    logic [31:0] brd;
    logic        irq;
    logic        srst;
    logic        ext;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kwd_watchdog #(.UNIT_TICKS(U), .PULSE_CLKS(P)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bwd),
        .bus_rdata_o(brd), .irq_o(irq), .sys_rst_req_o(srst), .ext_rst_o(ext)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bv = 1'b1; bw = 1'b1; ba = a; bwd = d;
        @(negedge clk);
        bv = 1'b0; bw = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bv = 1'b1; bw = 1'b0; ba = a;
        @(negedge clk);
        d = brd; bv = 1'b0;
    endtask

    task automatic arm(input logic [31:0] ctrl, input int len);
        wr(8'h00, ctrl);
        wr(8'h04, (32'(len) << 5) | 32'h8);
        wr(8'h08, 32'h1971);
    endtask

    // Clocks until the wanted event; -1 if none within limit.
    task automatic wait_evt(input bit want_irq, input int limit, output int n, output bit other);
        bit hit;
        hit = 1'b0; other = 1'b0; n = 0;
        while (!hit && n < limit) begin
            @(negedge clk);
            n++;
            if (want_irq ? irq : srst) hit = 1'b1;
            else if (want_irq ? srst : irq) other = 1'b1;
        end
        if (!hit) n = -1;
    endtask

    task automatic count_pin(input logic lvl, output int c);
        c = (ext === lvl) ? 1 : 0;
        for (int i = 0; i < 39; i++) begin
            @(negedge clk);
            if (ext === lvl) c++;
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        int c;
        bit o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 sysrst", 32'(srst), 0);
        check("R1 pin", 32'(ext), 1);
        rd(8'h00, d); check("R1 ctrl", d, 32'h5);
        rd(8'h04, d); check("R1 len", d, 32'hFFFF_FFE0);

        // R2 keyed control writes
        wr(8'h00, 32'h2200_0FFF); rd(8'h00, d); check("R2 keyed", d, 32'h15F);
        wr(8'h00, 32'h3300_0000); rd(8'h00, d); check("R2 wrong key", d, 32'h15F);
        wr(8'h00, 32'h2300_0000); rd(8'h00, d); check("R2 near key", d, 32'h15F);

        // R3 keyed length writes
        wr(8'h04, 32'h0000_0068); rd(8'h04, d); check("R3 keyed", d, 32'h60);
        wr(8'h04, 32'h0000_1007); rd(8'h04, d); check("R3 wrong key", d, 32'h60);

        // R4 and R6: single-stage timing sweep
        for (int len = 0; len <= 6; len++) begin
            arm(32'h2200_0005, len);
            wait_evt(1'b0, 200, n, o);
            check("R4 expiry clocks", 32'(n), 32'((len == 0 ? 1 : len) * U));
            check("R6 no irq", 32'(o), 0);
        end
        arm(32'h2200_0045, 3);
        wait_evt(1'b0, 200, n, o);
        check("R6 two-stage without irq", 32'(n), 32'(3 * U));
        check("R6 no irq (two-stage only)", 32'(o), 0);
        arm(32'h2200_000D, 3);
        wait_evt(1'b0, 200, n, o);
        check("R6 irq without two-stage", 32'(n), 32'(3 * U));
        check("R6 no irq (irq only)", 32'(o), 0);

        // R7 two-stage sequence sweep
        for (int len = 1; len <= 4; len++) begin
            arm(32'h2200_004D, len);
            wait_evt(1'b1, 200, n, o);
            check("R7 first stage", 32'(n), 32'(len * U));
            check("R7 no early reset", 32'(o), 0);
            wait_evt(1'b0, 200, n, o);
            check("R7 second stage", 32'(n), 32'(len * U));
            check("R6 irq cleared on reset", 32'(irq), 0);
        end
        arm(32'h2200_004D, 3);
        wait_evt(1'b1, 200, n, o);
        repeat (2) @(negedge clk);
        wr(8'h08, 32'h1971);
        check("R5 restart clears irq", 32'(irq), 0);
        wait_evt(1'b1, 200, n, o);
        check("R7 rescued restarts stage one", 32'(n), 32'(3 * U));
        check("R7 rescued no reset", 32'(o), 0);

        // R5 restart value exactness
        arm(32'h2200_0005, 4);
        repeat (6) @(negedge clk);
        wr(8'h08, 32'h1970);
        wait_evt(1'b0, 200, n, o);
        check("R5 wrong value ignored", 32'(n), 32'(4 * U - 7));
        arm(32'h2200_0005, 4);
        repeat (10) @(negedge clk);
        wr(8'h08, 32'h1971);
        wait_evt(1'b0, 200, n, o);
        check("R5 restart reloads", 32'(n), 32'(4 * U));

        // R9 disable holds, re-enable runs a full period
        arm(32'h2200_0005, 2);
        wr(8'h00, 32'h2200_0004);
        wait_evt(1'b0, 100, n, o);
        check("R9 stopped", 32'(n), 32'hFFFF_FFFF);
        wr(8'h00, 32'h2200_0005);
        wait_evt(1'b0, 200, n, o);
        check("R9 full period after enable", 32'(n), 32'(2 * U));

        // R11 no progress without ticks
        tick = 1'b0;
        arm(32'h2200_0005, 2);
        wait_evt(1'b0, 60, n, o);
        check("R11 no ticks no expiry", 32'(n), 32'hFFFF_FFFF);
        tick = 1'b1;
        wait_evt(1'b0, 200, n, o);
        check("R11 ticks resume", 32'(n), 32'(2 * U));

        // R8 software reset, counter stopped
        wr(8'h00, 32'h2200_0004);
        repeat (P + 2) @(negedge clk);
        wr(8'h14, 32'h1208);
        check("R8 wrong value", 32'(srst), 0);
        wait_evt(1'b0, 20, n, o);
        check("R8 no late reset", 32'(n), 32'hFFFF_FFFF);
        wr(8'h14, 32'h1209);
        check("R8 immediate", 32'(srst), 1);

        // R10 pin pulse, both polarities and disabled
        count_pin(1'b0, c);
        check("R10 active-low width", 32'(c), 32'(P));
        wr(8'h00, 32'h2200_0006);
        check("R10 high-pol idle", 32'(ext), 0);
        wr(8'h14, 32'h1209);
        count_pin(1'b1, c);
        check("R10 active-high width", 32'(c), 32'(P));
        wr(8'h00, 32'h2200_0002);
        wr(8'h14, 32'h1209);
        count_pin(1'b1, c);
        check("R10 pin disabled", 32'(c), 0);
        arm(32'h2200_0005, 2);
        wait_evt(1'b0, 200, n, o);
        check("R10 pin on expiry", 32'(ext), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule